// File: doc/BRIEF.md
# SPI FIFO and Interrupt Controller

This block is the buffering and event layer of a serial peripheral controller. It sits between a register bus and the shift engine. Two queues of eight words each carry data: the transmit queue is filled by bus writes and drained by the engine, and the receive queue is filled by the engine and drained by bus reads. A control word sets a transmit threshold and a receive threshold and can flush either queue. The same thresholds drive the two DMA request levels.

A small interrupt unit gathers the events: a sticky receive overrun, a sticky receive-complete, a sticky transfer-complete and the two DMA request levels. Each source has an enable bit and, where it is sticky, a write-one-to-clear bit. One interrupt line is the OR of every source that is both active and enabled. A status word reports whether the receive queue holds data and whether the controller is still busy.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: After reset both queues are empty, all sticky status bits are clear, all enables are clear, the interrupt line is low, both thresholds are 1, and the status word reads 0.
- R2: Each queue holds up to DEPTH (8) words and delivers them in the order pushed. A push into a full transmit queue is dropped. A pop from an empty queue has no effect.
- R3: A receive word that arrives while the receive queue is full is dropped and sets interrupt status bit 0 (overrun). The bit stays set until cleared, and the queue contents are unchanged.
- R4: A control-word write with bit 12 set empties the transmit queue, and one with bit 4 set empties the receive queue. A flush overrides a push or pop in the same cycle and leaves the other queue untouched.
- R5: Each control-word write loads the receive threshold from bits 3:0 and the transmit threshold from bits 11:8. While the receive count is at least the receive threshold, the RX DMA request output and interrupt status bits 1 and 9 are high.
- R6: While the number of free transmit entries is at least the transmit threshold, the TX DMA request output and interrupt status bit 2 are high.
- R7: Interrupt status bit 3 (receive complete) is set when the receive count is at least the receive threshold while the engine is not busy. The bit is not set while the engine is busy. It is visible one cycle after the condition holds.
- R8: Interrupt status bit 4 (transfer complete) is set by an engine word-done strobe that arrives while the transmit queue is empty, and not otherwise.
- R9: A clear write with bit 0, 3 or 4 set clears overrun, receive complete or transfer complete respectively. If the setting condition is present in the same cycle, the bit stays set.
- R10: The interrupt line is high when any of the sources overrun (enable bit 0), RX DMA request (bit 1), TX DMA request (bit 2), receive complete (bit 3) or transfer complete (bit 4) is active and its enable is set.
- R11: Status word bit 0 is high when the receive queue is not empty. Bit 7 (busy) is high when the engine is busy or the transmit queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_push | input | 1 | Bus write of a transmit word |
| tx_wdata | input | DW | Transmit word written by the bus |
| tx_pop | input | 1 | Engine takes the head transmit word |
| tx_rdata | output | DW | Head of the transmit queue |
| rx_push | input | 1 | Engine delivers a received word |
| rx_wdata | input | DW | Received word from the engine |
| rx_pop | input | 1 | Bus read of the head receive word |
| rx_rdata | output | DW | Head of the receive queue |
| eng_busy | input | 1 | Engine is shifting |
| eng_word_done | input | 1 | Engine finished one word |
| fc_wr | input | 1 | Control-word write strobe |
| fc_wdata | input | 16 | Control word: thresholds and flush bits |
| ie_wr | input | 1 | Enable-register write strobe |
| ie_wdata | input | 5 | Interrupt enable bits |
| ic_wr | input | 1 | Clear-register write strobe |
| ic_wdata | input | 5 | Write-one-to-clear bits |
| stat_o | output | 8 | Status word |
| ists_o | output | 10 | Interrupt status word |
| irq_o | output | 1 | Interrupt line |
| tx_dreq_o | output | 1 | TX DMA request level |
| rx_dreq_o | output | 1 | RX DMA request level |
| tx_level_o | output | CW | Transmit queue occupancy |
| rx_level_o | output | CW | Receive queue occupancy |

## Verification
The queues are tested with full sequences of distinct words, including a push beyond capacity, so that the delivery order and the handling of a dropped word can both be observed. The threshold levels are tested just below and exactly at the programmed value, which shows whether the comparisons are inclusive. The sticky bits are tested with a clear that arrives while the setting condition still holds and with a clear that arrives after it has gone, which shows the priority of the event over the clear. Receive complete and transfer complete are each tested with the enabling condition present and absent (engine busy, transmit queue not empty).

// File: rtl/spfi_pkg.sv
package spfi_pkg;
  // control word fields
  localparam int FC_W        = 16;
  localparam int FC_RXTH_LSB = 0;
  localparam int FC_RXFL     = 4;
  localparam int FC_TXTH_LSB = 8;
  localparam int FC_TXFL     = 12;
  // interrupt source indices (enable, status and clear share them)
  localparam int IE_W    = 5;
  localparam int EV_OVR  = 0;
  localparam int EV_RXDQ = 1;
  localparam int EV_TXDQ = 2;
  localparam int EV_RC   = 3;
  localparam int EV_TC   = 4;
  localparam int IS_W     = 10;
  localparam int IS_RXHIT = 9;
  // status word
  localparam int SR_W    = 8;
  localparam int SR_RXNE = 0;
  localparam int SR_BUSY = 7;
endpackage

// File: rtl/spfi_fifo.sv
module spfi_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;

  // storage without reset so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
    end
  end
  assign count = cnt;

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  p_push_grows_r2: assert property (@(posedge clk) disable iff (rst)
    (push && !full && !pop && !flush) |=> (cnt == $past(cnt) + 1'b1));
  p_flush_clears_r4: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/spfi_irq.sv
module spfi_irq
  import spfi_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ovr_evt,
  input  logic            rc_evt,
  input  logic            tc_evt,
  input  logic            rx_dreq,
  input  logic            tx_dreq,
  input  logic            rx_hit,
  input  logic            ie_wr,
  input  logic [IE_W-1:0] ie_wdata,
  input  logic            ic_wr,
  input  logic [IE_W-1:0] ic_wdata,
  output logic [IS_W-1:0] ists,
  output logic            irq
);
  logic [IE_W-1:0] ie_q;
  logic            ovr_q, rc_q, tc_q;
  logic [IE_W-1:0] clr, src;
  logic            unused_clr;

  assign clr        = ic_wr ? ic_wdata : '0;
  assign unused_clr = ^{clr[EV_RXDQ], clr[EV_TXDQ]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q  <= '0;
      ovr_q <= 1'b0;
      rc_q  <= 1'b0;
      tc_q  <= 1'b0;
    end else begin
      if (ie_wr) ie_q <= ie_wdata;
      // the event wins over a clear in the same cycle
      ovr_q <= ovr_evt | (ovr_q & ~clr[EV_OVR]);
      rc_q  <= rc_evt  | (rc_q  & ~clr[EV_RC]);
      tc_q  <= tc_evt  | (tc_q  & ~clr[EV_TC]);
    end
  end

  always_comb begin
    src          = '0;
    src[EV_OVR]  = ovr_q;
    src[EV_RXDQ] = rx_dreq;
    src[EV_TXDQ] = tx_dreq;
    src[EV_RC]   = rc_q;
    src[EV_TC]   = tc_q;
    ists           = '0;
    ists[IE_W-1:0] = src;
    ists[IS_RXHIT] = rx_hit;
  end
  assign irq = |(src & ie_q);

  p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !clr[EV_OVR]) |=> ovr_q);
  p_event_wins_r9: assert property (@(posedge clk) disable iff (rst)
    rc_evt |=> rc_q);
  p_tc_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (clr[EV_TC] && !tc_evt) |=> !tc_q);
  p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ie_q != '0));
endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
  import spfi_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int TH_W  = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tx_push,
  input  logic [DW-1:0]   tx_wdata,
  input  logic            tx_pop,
  output logic [DW-1:0]   tx_rdata,
  input  logic            rx_push,
  input  logic [DW-1:0]   rx_wdata,
  input  logic            rx_pop,
  output logic [DW-1:0]   rx_rdata,
  input  logic            eng_busy,
  input  logic            eng_word_done,
  input  logic            fc_wr,
  input  logic [FC_W-1:0] fc_wdata,
  input  logic            ie_wr,
  input  logic [IE_W-1:0] ie_wdata,
  input  logic            ic_wr,
  input  logic [IE_W-1:0] ic_wdata,
  output logic [SR_W-1:0] stat_o,
  output logic [IS_W-1:0] ists_o,
  output logic            irq_o,
  output logic            tx_dreq_o,
  output logic            rx_dreq_o,
  output logic [CW-1:0]   tx_level_o,
  output logic [CW-1:0]   rx_level_o
);
  logic [TH_W-1:0] tx_th, rx_th;
  logic            tx_flush, rx_flush;
  logic [CW-1:0]   tx_cnt, rx_cnt, tx_free;
  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic            rx_hit, tx_room;
  logic            unused_fc;

  assign tx_flush  = fc_wr & fc_wdata[FC_TXFL];
  assign rx_flush  = fc_wr & fc_wdata[FC_RXFL];
  assign unused_fc = ^{fc_wdata[FC_W-1:FC_TXFL+1], fc_wdata[FC_TXTH_LSB-1:FC_RXFL+1], tx_full};

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_th <= TH_W'(1);
      rx_th <= TH_W'(1);
    end else if (fc_wr) begin
      tx_th <= fc_wdata[FC_TXTH_LSB +: TH_W];
      rx_th <= fc_wdata[FC_RXTH_LSB +: TH_W];
    end
  end

  spfi_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spfi_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  assign tx_free = CW'(DEPTH) - tx_cnt;
  assign rx_hit  = int'(rx_cnt)  >= int'(rx_th);
  assign tx_room = int'(tx_free) >= int'(tx_th);

  spfi_irq u_irq (
    .clk(clk), .rst(rst),
    .ovr_evt(rx_push & rx_full),
    .rc_evt(rx_hit & ~eng_busy),
    .tc_evt(eng_word_done & tx_empty),
    .rx_dreq(rx_hit), .tx_dreq(tx_room), .rx_hit(rx_hit),
    .ie_wr(ie_wr), .ie_wdata(ie_wdata),
    .ic_wr(ic_wr), .ic_wdata(ic_wdata),
    .ists(ists_o), .irq(irq_o));

  always_comb begin
    stat_o          = '0;
    stat_o[SR_RXNE] = ~rx_empty;
    stat_o[SR_BUSY] = eng_busy | ~tx_empty;
  end

  assign tx_dreq_o  = tx_room;
  assign rx_dreq_o  = rx_hit;
  assign tx_level_o = tx_cnt;
  assign rx_level_o = rx_cnt;

  p_overrun_keeps_level_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_full && !rx_pop && !rx_flush) |=> (rx_cnt == CW'(DEPTH)));
  p_rxne_tracks_r11: assert property (@(posedge clk) disable iff (rst)
    stat_o[SR_RXNE] == (rx_level_o != '0));
endmodule

// File: tb/sim_spi_fifo_irq_ctrl.sv
module sim_spi_fifo_irq_ctrl;
  localparam int DW = 32;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [DW-1:0] tx_wdata = '0, rx_wdata = '0;
  logic [DW-1:0] tx_rdata, rx_rdata;
  logic eng_busy = 0, eng_word_done = 0;
  logic fc_wr = 0, ie_wr = 0, ic_wr = 0;
  logic [15:0] fc_wdata = '0;
  logic [4:0] ie_wdata = '0, ic_wdata = '0;
  logic [7:0] stat_o;
  logic [9:0] ists_o;
  logic irq_o, tx_dreq_o, rx_dreq_o;
  logic [CW-1:0] tx_level_o, rx_level_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_fifo_irq_ctrl u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic txw(input logic [31:0] d); tx_push = 1; tx_wdata = d; step(); tx_push = 0; endtask
  task automatic rxw(input logic [31:0] d); rx_push = 1; rx_wdata = d; step(); rx_push = 0; endtask
  task automatic fcw(input logic [15:0] v); fc_wr = 1; fc_wdata = v; step(); fc_wr = 0; endtask
  task automatic iew(input logic [4:0] v); ie_wr = 1; ie_wdata = v; step(); ie_wr = 0; endtask
  task automatic icw(input logic [4:0] v); ic_wr = 1; ic_wdata = v; step(); ic_wr = 0; endtask

  task automatic t_reset();
    chk("R1 stat", stat_o, 0);
    chk("R1 ists (only tx dreq)", ists_o, 10'h004);
    chk("R1 irq", irq_o, 0);
    chk("R1 tx level", tx_level_o, 0);
    chk("R1 rx level", rx_level_o, 0);
  endtask

  task automatic t_order();
    txw(32'hA000_0000);
    chk("R11 busy with tx data", stat_o[7], 1);
    for (int i = 1; i < 9; i++) txw(32'hA000_0000 + i);
    chk("R2 tx full level, 9th dropped", tx_level_o, 8);
    for (int i = 0; i < 8; i++) begin
      chk("R2 tx order", tx_rdata, 32'hA000_0000 + i);
      tx_pop = 1; step(); tx_pop = 0;
    end
    tx_pop = 1; step(); tx_pop = 0;
    chk("R2 pop on empty", tx_level_o, 0);
    chk("R11 not busy", stat_o[7], 0);
  endtask

  task automatic t_overrun();
    icw(5'h1F);
    for (int i = 0; i < 8; i++) rxw(32'hB000_0000 + i);
    chk("R3 no overrun when just full", ists_o[0], 0);
    chk("R11 rx not empty", stat_o[0], 1);
    rxw(32'hDEAD_BEEF);
    chk("R3 overrun set", ists_o[0], 1);
    chk("R3 level unchanged", rx_level_o, 8);
    for (int i = 0; i < 8; i++) begin
      chk("R3 rx data kept", rx_rdata, 32'hB000_0000 + i);
      rx_pop = 1; step(); rx_pop = 0;
    end
    chk("R3 overrun sticky", ists_o[0], 1);
    icw(5'h01);
    chk("R9 overrun cleared", ists_o[0], 0);
  endtask

  task automatic t_thresh();
    fcw(16'h0603);
    rxw(1); rxw(2);
    chk("R5 rx dreq below th", rx_dreq_o, 0);
    chk("R5 ists9 below th", ists_o[9], 0);
    rxw(3);
    chk("R5 rx dreq at th", rx_dreq_o, 1);
    chk("R5 ists bits 9,1", {ists_o[9], ists_o[1]}, 2'b11);
    txw(1); txw(2);
    chk("R6 tx dreq free 6", tx_dreq_o, 1);
    txw(3);
    chk("R6 tx dreq free 5", tx_dreq_o, 0);
    chk("R6 ists2 free 5", ists_o[2], 0);
    rx_push = 1; rx_wdata = 9; fcw(16'h0613); rx_push = 0;
    chk("R4 rx flushed over push", rx_level_o, 0);
    chk("R4 tx untouched", tx_level_o, 3);
    fcw(16'h1603);
    chk("R4 tx flushed", tx_level_o, 0);
    fcw(16'h0101);
  endtask

  task automatic t_rc();
    eng_busy = 1;
    fcw(16'h0102);
    icw(5'h1F);
    rxw(1); rxw(2); step();
    chk("R7 no rc while busy", ists_o[3], 0);
    eng_busy = 0; step();
    chk("R7 rc set when idle", ists_o[3], 1);
    icw(5'h08);
    chk("R9 event beats clear", ists_o[3], 1);
    rx_pop = 1; step(); rx_pop = 0;
    icw(5'h08);
    chk("R9 rc cleared", ists_o[3], 0);
    fcw(16'h0111);
  endtask

  task automatic t_tc();
    icw(5'h1F);
    eng_word_done = 1; step(); eng_word_done = 0;
    chk("R8 tc set on empty tx", ists_o[4], 1);
    icw(5'h10);
    chk("R9 tc cleared", ists_o[4], 0);
    txw(5);
    eng_word_done = 1; step(); eng_word_done = 0;
    chk("R8 no tc with tx data", ists_o[4], 0);
    fcw(16'h1101);
  endtask

  task automatic t_irq();
    icw(5'h1F);
    chk("R10 no enable", irq_o, 0);
    iew(5'b00100);
    chk("R10 tx dreq enabled", irq_o, 1);
    iew(5'b00000);
    chk("R10 disabled", irq_o, 0);
    rxw(7); step();
    iew(5'b01000);
    chk("R10 rc enabled", irq_o, 1);
    iew(5'b00010);
    chk("R10 rx dreq enabled", irq_o, 1);
    fcw(16'h0111);
    chk("R10 rx dreq gone", irq_o, 0);
    iew(5'b00000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    t_reset();
    t_order();
    t_overrun();
    t_thresh();
    t_rc();
    t_tc();
    t_irq();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule